// File: doc/BRIEF.md
# Processor Interrupt Recognition Unit

This unit sits in front of a small processor core and decides when an external interrupt is taken. It watches two request inputs. The first is an urgent request that cannot be masked and is recognised on its rising edge. The second is a maskable request that is recognised by its level and may change at any time relative to the clock. The core raises a one-cycle `boundary` strobe whenever a new interrupt may be taken: at the start of each instruction, and after each iteration of a repeated string instruction. Requests are considered only on that strobe.

An urgent request always delivers vector 2. It marks a handler as in progress until the core strobes `iretStrobe`. An urgent edge that arrives while the handler is in progress is kept pending and is served after the return. A maskable request is first passed through a two-flop synchroniser and then a glitch filter that needs a minimum run of high cycles. It is taken only when the core's interrupt-enable flag is set. It then runs two acknowledge bus cycles back to back and delivers the byte read in the second of them as the vector.

Top module: `irq_recog`

## Requirements
- R1: After reset, `takeValid`, `ackStrobe`, `clearIf` and `nmiActive` are all 0.
- R2: A pending urgent request, seen at a boundary while no urgent handler is active, gives a one-cycle `takeValid` pulse in the next cycle with `takeNmi`=1 and `takeVector`=2. `nmiActive` rises at the same time.
- R3: While `nmiActive`=1, a new urgent edge is not taken. It stays pending, and the first boundary after `iretStrobe` takes it.
- R4: `clearIf` pulses with an urgent take when `realMode`=1, and stays 0 when `realMode`=0.
- R5: The maskable input counts as valid only after its synchronised value has been high for at least HOLD_CYCLES (default 8) consecutive clocks. Counting starts two clocks after the input rises. A shorter high time is not taken.
- R6: A valid maskable request at a boundary is ignored while `ifFlag`=0. It is taken at a later boundary once `ifFlag`=1.
- R7: No request is taken in a cycle without `boundary`.
- R8: A taken maskable request drives `ackStrobe`, first with `ackCycle`=0 and then with `ackCycle`=1. Each phase is held until `ackReady`=1. `takeValid` pulses in the cycle after the second ready, with `takeNmi`=0 and `takeVector` equal to the `dataBus` byte of the second phase only.
- R9: When both requests are takeable at the same boundary, the urgent request is taken and no acknowledge cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiIn | input | 1 | Urgent request, taken on its rising edge |
| intrIn | input | 1 | Maskable request, level, may be asynchronous |
| boundary | input | 1 | Instruction or string-iteration boundary strobe |
| ifFlag | input | 1 | Interrupt-enable flag from the core |
| realMode | input | 1 | Core is in real mode |
| iretStrobe | input | 1 | Return-from-interrupt strobe |
| ackReady | input | 1 | Ready for the current acknowledge bus cycle |
| dataBus | input | 8 | Data bus, carries the vector in the second acknowledge cycle |
| ackStrobe | output | 1 | Acknowledge bus cycle in progress |
| ackCycle | output | 1 | 0 = first acknowledge cycle, 1 = second |
| takeValid | output | 1 | One-cycle pulse: interrupt taken |
| takeNmi | output | 1 | The taken interrupt is the urgent one |
| takeVector | output | 8 | Vector number, valid with `takeValid` |
| clearIf | output | 1 | Pulse asking the core to clear its enable flag |
| nmiActive | output | 1 | Urgent handler in progress |

## Verification
Most internal faults in this block show up at the boundary that follows them. A lost pending edge or a stuck `nmiActive` shows as a missing or extra urgent take one cycle after a boundary. A glitch-filter counter that is off by one moves the earliest accepted boundary by one clock. A state machine that skips or repeats an acknowledge phase shows in the `ackCycle` sequence, or in a vector taken from the wrong phase, within one cycle of `ackReady`.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK1 = 2'd1,
    ST_ACK2 = 2'd2,
    ST_DONE = 2'd3
  } irqState_t;

  typedef struct packed {
    logic takeNmi;
    logic latchVec;
  } irqStrobes_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int HOLD_CYCLES = 8,
  parameter int VEC_W       = 8,
  parameter int NMI_VECTOR  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiIn,
  input  logic             intrIn,
  input  logic             iretStrobe,
  input  logic [VEC_W-1:0] dataBus,
  input  irqStrobes_t      strb,
  output logic             nmiPend,
  output logic             nmiActive,
  output logic             intrValid,
  output logic [VEC_W-1:0] vecReg
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_CYCLES);

  logic [1:0]       intrSync;
  logic [1:0]       nmiSync;
  logic             nmiPrev;
  logic [CNT_W-1:0] highCnt;
  logic             nmiEdge;

  assign nmiEdge   = nmiSync[1] & ~nmiPrev;
  assign intrValid = (highCnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intrSync  <= '0;
      nmiSync   <= '0;
      nmiPrev   <= 1'b0;
      highCnt   <= '0;
      nmiPend   <= 1'b0;
      nmiActive <= 1'b0;
      vecReg    <= '0;
    end else begin
      intrSync <= {intrSync[0], intrIn};
      nmiSync  <= {nmiSync[0], nmiIn};
      nmiPrev  <= nmiSync[1];
      if (!intrSync[1])
        highCnt <= '0;
      else if (highCnt != CNT_MAX)
        highCnt <= highCnt + 1'b1;
      nmiPend   <= nmiEdge | (nmiPend & ~strb.takeNmi);
      nmiActive <= strb.takeNmi | (nmiActive & ~iretStrobe);
      if (strb.takeNmi)
        vecReg <= VEC_W'(NMI_VECTOR);
      else if (strb.latchVec)
        vecReg <= dataBus;
    end
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        boundary,
  input  logic        ifFlag,
  input  logic        realMode,
  input  logic        ackReady,
  input  logic        nmiPend,
  input  logic        nmiActive,
  input  logic        intrValid,
  output irqStrobes_t strb,
  output logic        ackStrobe,
  output logic        ackCycle,
  output logic        takeValid,
  output logic        takeNmi,
  output logic        clearIf
);
  irqState_t state, stateNext;
  logic      doneNmi, doneNmiNext;

  always_comb begin
    stateNext   = state;
    doneNmiNext = doneNmi;
    strb        = '0;
    unique case (state)
      ST_IDLE: begin
        if (boundary) begin
          if (nmiPend && !nmiActive) begin
            strb.takeNmi = 1'b1;
            doneNmiNext  = 1'b1;
            stateNext    = ST_DONE;
          end else if (intrValid && ifFlag) begin
            doneNmiNext = 1'b0;
            stateNext   = ST_ACK1;
          end
        end
      end
      ST_ACK1: if (ackReady) stateNext = ST_ACK2;
      ST_ACK2: begin
        if (ackReady) begin
          strb.latchVec = 1'b1;
          stateNext     = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneNmi <= 1'b0;
    end else begin
      state   <= stateNext;
      doneNmi <= doneNmiNext;
    end
  end

  assign ackStrobe = (state == ST_ACK1) || (state == ST_ACK2);
  assign ackCycle  = (state == ST_ACK2);
  assign takeValid = (state == ST_DONE);
  assign takeNmi   = takeValid & doneNmi;
  assign clearIf   = takeNmi & realMode;
endmodule

// File: rtl/irq_recog.sv
module irq_recog
  import irq_pkg::*;
#(
  parameter int HOLD_CYCLES = 8,
  parameter int VEC_W       = 8,
  parameter int NMI_VECTOR  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             nmiIn,
  input  logic             intrIn,
  input  logic             boundary,
  input  logic             ifFlag,
  input  logic             realMode,
  input  logic             iretStrobe,
  input  logic             ackReady,
  input  logic [VEC_W-1:0] dataBus,
  output logic             ackStrobe,
  output logic             ackCycle,
  output logic             takeValid,
  output logic             takeNmi,
  output logic [VEC_W-1:0] takeVector,
  output logic             clearIf,
  output logic             nmiActive
);
  irqStrobes_t strb;
  logic        nmiPend;
  logic        intrValid;

  irq_datapath #(
    .HOLD_CYCLES(HOLD_CYCLES),
    .VEC_W(VEC_W),
    .NMI_VECTOR(NMI_VECTOR)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .intrIn(intrIn),
    .iretStrobe(iretStrobe), .dataBus(dataBus), .strb(strb),
    .nmiPend(nmiPend), .nmiActive(nmiActive), .intrValid(intrValid),
    .vecReg(takeVector)
  );

  irq_control i_control (
    .clk(clk), .rstN(rstN), .boundary(boundary), .ifFlag(ifFlag),
    .realMode(realMode), .ackReady(ackReady), .nmiPend(nmiPend),
    .nmiActive(nmiActive), .intrValid(intrValid), .strb(strb),
    .ackStrobe(ackStrobe), .ackCycle(ackCycle), .takeValid(takeValid),
    .takeNmi(takeNmi), .clearIf(clearIf)
  );
endmodule

// File: rtl/irq_recog_checker.sv
module irq_recog_checker #(
  parameter int VEC_W      = 8,
  parameter int NMI_VECTOR = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             boundary,
  input logic             ackReady,
  input logic             ackStrobe,
  input logic             ackCycle,
  input logic             takeValid,
  input logic             takeNmi,
  input logic [VEC_W-1:0] takeVector,
  input logic             clearIf,
  input logic             nmiActive
);
  assert_nmi_vector_R2: assert property (@(posedge clk) disable iff (!rstN)
    takeNmi |-> takeValid && takeVector == VEC_W'(NMI_VECTOR));

  assert_take_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    takeValid |=> !takeValid);

  assert_active_on_take_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiActive) |-> takeValid && takeNmi);

  assert_clear_if_R4: assert property (@(posedge clk) disable iff (!rstN)
    clearIf |-> takeValid && takeNmi);

  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe && !ackReady |=> ackStrobe && $stable(ackCycle));

  assert_ack_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    takeValid && !takeNmi |-> $past(ackStrobe && ackCycle && ackReady));

  assert_start_at_boundary_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackStrobe) |-> $past(boundary));
endmodule

bind irq_recog irq_recog_checker #(.VEC_W(VEC_W), .NMI_VECTOR(NMI_VECTOR)) i_checker (
  .clk(clk), .rstN(rstN), .boundary(boundary), .ackReady(ackReady),
  .ackStrobe(ackStrobe), .ackCycle(ackCycle), .takeValid(takeValid),
  .takeNmi(takeNmi), .takeVector(takeVector), .clearIf(clearIf),
  .nmiActive(nmiActive)
);

// File: tb/test_irq_recog.sv
module test_irq_recog;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int N_TBL      = 4;
  // each entry: {byte on first ack phase, byte on second ack phase}
  localparam logic [15:0] ACK_TBL [N_TBL] = '{16'h115A, 16'hA5C3, 16'h00FF, 16'h7E01};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       nmiIn = 1'b0, intrIn = 1'b0, boundary = 1'b0, ifFlag = 1'b1;
  logic       realMode = 1'b1, iretStrobe = 1'b0, ackReady = 1'b0;
  logic [7:0] dataBus = 8'h00;
  logic       ackStrobe, ackCycle, takeValid, takeNmi, clearIf, nmiActive;
  logic [7:0] takeVector;
  int total = 0, bad = 0, cycles = 0;
  logic finished = 1'b0;

  irq_recog i_irq_recog (
    .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .intrIn(intrIn), .boundary(boundary),
    .ifFlag(ifFlag), .realMode(realMode), .iretStrobe(iretStrobe),
    .ackReady(ackReady), .dataBus(dataBus), .ackStrobe(ackStrobe),
    .ackCycle(ackCycle), .takeValid(takeValid), .takeNmi(takeNmi),
    .takeVector(takeVector), .clearIf(clearIf), .nmiActive(nmiActive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !finished) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseNmi();
    nmiIn = 1'b1; cyc(3); nmiIn = 1'b0; cyc(2);
  endtask

  task automatic hitBoundary();
    boundary = 1'b1; cyc(1); boundary = 1'b0;
  endtask

  task automatic doIret();
    iretStrobe = 1'b1; cyc(1); iretStrobe = 1'b0;
  endtask

  // acknowledge phases with ready at once; checks R8
  task automatic runAck(input logic [7:0] first, input logic [7:0] second, input string tag);
    chk({tag, " R8 phase1"}, {ackStrobe, ackCycle}, 2'b10);
    ackReady = 1'b1; dataBus = first; cyc(1);
    chk({tag, " R8 phase2"}, {ackStrobe, ackCycle}, 2'b11);
    dataBus = second; cyc(1);
    chk({tag, " R8 take"}, {takeValid, takeNmi, ackStrobe}, 3'b100);
    chk({tag, " R8 vector"}, takeVector, second);
    ackReady = 1'b0; intrIn = 1'b0; cyc(1);
    chk({tag, " R8 pulse end"}, takeValid, 1'b0);
    cyc(3);
  endtask

  initial begin
    cyc(3);
    chk("R1 reset outputs", {takeValid, ackStrobe, clearIf, nmiActive}, 4'b0000);
    rstN = 1'b1; cyc(1);
    chk("R1 after release", {takeValid, ackStrobe, clearIf, nmiActive}, 4'b0000);

    // table-driven maskable takes
    for (int k = 0; k < N_TBL; k++) begin
      intrIn = 1'b1; cyc(10); hitBoundary();
      runAck(ACK_TBL[k][15:8], ACK_TBL[k][7:0], "tbl");
    end

    // R5: one clock short of the hold time, then exactly enough
    intrIn = 1'b1; cyc(9); hitBoundary();
    chk("R5 short high not taken", ackStrobe, 1'b0);
    hitBoundary();
    chk("R5 hold met taken", ackStrobe, 1'b1);
    runAck(8'h01, 8'h42, "R5");
    // R5: a low dip restarts the count
    intrIn = 1'b1; cyc(6); intrIn = 1'b0; cyc(1); intrIn = 1'b1; cyc(6); hitBoundary();
    chk("R5 dip restarts count", ackStrobe, 1'b0);
    intrIn = 1'b0; cyc(3);

    // R7: valid request without boundary
    intrIn = 1'b1; cyc(14);
    chk("R7 no boundary no take", {ackStrobe, takeValid}, 2'b00);
    // R6: flag clear blocks, later set allows
    ifFlag = 1'b0; hitBoundary();
    chk("R6 flag clear ignored", {ackStrobe, takeValid}, 2'b00);
    ifFlag = 1'b1; hitBoundary();
    chk("R6 taken when flag set", ackStrobe, 1'b1);
    // R8: phase waits for ready, first-phase byte discarded
    cyc(2);
    chk("R8 wait phase1", {ackStrobe, ackCycle}, 2'b10);
    ackReady = 1'b1; dataBus = 8'h99; cyc(1);
    ackReady = 1'b0; dataBus = 8'h33; cyc(2);
    chk("R8 wait phase2", {ackStrobe, ackCycle, takeValid}, 3'b110);
    ackReady = 1'b1; dataBus = 8'h6D; cyc(1);
    chk("R8 second byte only", {takeValid, takeVector}, {1'b1, 8'h6D});
    ackReady = 1'b0; intrIn = 1'b0; cyc(4);

    // R2/R4: urgent take in real mode
    realMode = 1'b1; pulseNmi(); hitBoundary();
    chk("R2 urgent take", {takeValid, takeNmi, takeVector}, {2'b11, 8'd2});
    chk("R4 clearIf real mode", clearIf, 1'b1);
    chk("R2 active set", nmiActive, 1'b1);
    cyc(1);
    chk("R2 single pulse", takeValid, 1'b0);
    // R3: blocked while active, served after return
    pulseNmi(); hitBoundary();
    chk("R3 blocked while active", takeValid, 1'b0);
    doIret();
    chk("R3 active cleared", nmiActive, 1'b0);
    realMode = 1'b0; hitBoundary();
    chk("R3 pending served after return", {takeValid, takeNmi}, 2'b11);
    chk("R4 no clearIf protected", clearIf, 1'b0);
    cyc(1); doIret();

    // R9: both at same boundary, urgent wins
    realMode = 1'b1; intrIn = 1'b1; pulseNmi(); cyc(5); hitBoundary();
    chk("R9 urgent wins", {takeValid, takeNmi, ackStrobe}, 3'b110);
    cyc(1); hitBoundary();
    chk("R9 maskable next", ackStrobe, 1'b1);
    runAck(8'h00, 8'h20, "R9");
    doIret();
    chk("R3 idle after return", {nmiActive, takeValid}, 2'b00);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule